// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of an 8-bit controller with a 64 KB code space. On every instruction step it computes the next counter value from one of four sources:

- a sequential advance by the instruction length;
- a signed 8-bit relative offset;
- a full 16-bit long target;
- an indexed target, formed as data pointer plus zero-extended accumulator.

The block also keeps a 16-bit data pointer that software loads one byte at a time. It drives a combinational code-table read address. That address is the accumulator added to either the data pointer or the address of the following instruction.

The sequencer that decodes instructions drives `step` once per executed instruction. It supplies the instruction length, a one-hot source select and the operands. An illegal select does not move the counter. It raises `sel_err` for the cycle after the step.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0000h, `dptr` is 0000h and `sel_err` is 0. Reset is asynchronous and active low.
- R2: In a cycle where `step` is 0, `pc` keeps its value whatever the other inputs hold.
- R3: A step with `src_sel` = 4'b0001 (sequential) sets `pc` to `pc + len`. Here `len` is the instruction length of 1, 2 or 3 bytes.
- R4: A step with `src_sel` = 4'b0010 (relative) sets `pc` to `pc + len + rel_off`. The offset `rel_off` is a two's-complement value in -128..+127.
- R5: A step with `src_sel` = 4'b0100 (long) loads `pc` with `long_tgt`.
- R6: A step with `src_sel` = 4'b1000 (indexed) loads `pc` with `dptr` plus the zero-extended `acc`. The `dptr` value used is the one held before that clock edge.
- R7: `code_addr` is combinational and equals zero-extended `acc` plus a base. The base is `dptr` when `tbl_pc_base` = 0. It is `pc + len` (the following instruction) when `tbl_pc_base` = 1.
- R8: `dp_wr` with `dp_hi` = 0 writes `dp_wdata` into `dptr[7:0]` and leaves `dptr[15:8]` unchanged. With `dp_hi` = 1 it writes `dptr[15:8]` and leaves `dptr[7:0]` unchanged.
- R9: All address arithmetic wraps modulo 65536.
- R10: A step whose `src_sel` is not one-hot, including all zeros, leaves `pc` unchanged. It sets `sel_err` to 1 for the next cycle only. In every other cycle `sel_err` reads 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | One executed instruction this cycle |
| src_sel | input | 4 | One-hot next-address source: bit0 sequential, bit1 relative, bit2 long, bit3 indexed |
| len | input | 2 | Instruction length in bytes (1..3) |
| rel_off | input | 8 | Signed relative offset |
| long_tgt | input | 16 | Long jump target |
| acc | input | 8 | Accumulator value for indexed modes |
| tbl_pc_base | input | 1 | Table-read base: 0 data pointer, 1 following instruction |
| dp_wr | input | 1 | Data pointer byte write strobe |
| dp_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| dp_wdata | input | 8 | Data pointer byte write value |
| pc | output | 16 | Program counter |
| dptr | output | 16 | Data pointer |
| code_addr | output | 16 | Indexed code-table read address |
| sel_err | output | 1 | Illegal source select seen on the previous step |

## Verification
The bench aims at these corner cases:

- **Negative relative offset.** An offset of -128 crosses below 0000h. A design that zero-extended the offset would jump forward. A design that added it before the length would land two bytes short.
- **Wrap at the top of the space.** A sequential step from FFFFh and a table read with the data pointer at FFFFh must both wrap to low addresses.
- **Partial pointer writes.** Writing one byte of the pointer must not disturb the other byte.
- **Write during an indexed jump.** When the jump shares a cycle with a pointer write, it must use the old pointer.
- **Illegal selects.** Two-hot and all-zero selects must freeze the counter. They must pulse the error flag for exactly one cycle, not latch it.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [3:0]    src_sel,
  input  logic [1:0]    len,
  input  logic [DW-1:0] rel_off,
  input  logic [AW-1:0] long_tgt,
  input  logic [DW-1:0] acc,
  input  logic          tbl_pc_base,
  input  logic          dp_wr,
  input  logic          dp_hi,
  input  logic [DW-1:0] dp_wdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] dptr,
  output logic [AW-1:0] code_addr,
  output logic          sel_err
);
  localparam int SEQ = 0;
  localparam int REL = 1;
  localparam int LNG = 2;
  localparam int IDX = 3;

  logic [AW-1:0] pc_q, dptr_q, pc_d;
  logic [AW-1:0] seq_addr, rel_addr, idx_addr, acc_z;
  logic          sel_ok;

  assign acc_z    = {{(AW-DW){1'b0}}, acc};
  assign seq_addr = pc_q + {{(AW-2){1'b0}}, len};
  assign rel_addr = seq_addr + {{(AW-DW){rel_off[DW-1]}}, rel_off};
  assign idx_addr = dptr_q + acc_z;
  assign sel_ok   = (src_sel != 4'b0) && ((src_sel & (src_sel - 4'd1)) == 4'b0);

  always_comb begin
    pc_d = pc_q;
    if (step && sel_ok) begin
      unique case (1'b1)
        src_sel[SEQ]: pc_d = seq_addr;
        src_sel[REL]: pc_d = rel_addr;
        src_sel[LNG]: pc_d = long_tgt;
        src_sel[IDX]: pc_d = idx_addr;
        default:      pc_d = pc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sel_err <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      sel_err <= step && !sel_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dptr_q <= '0;
    else if (dp_wr) begin
      if (dp_hi) dptr_q[AW-1:DW] <= dp_wdata[AW-DW-1:0];
      else       dptr_q[DW-1:0]  <= dp_wdata;
    end
  end

  assign pc        = pc_q;
  assign dptr      = dptr_q;
  assign code_addr = acc_z + (tbl_pc_base ? seq_addr : dptr_q);
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [3:0]  src_sel,
  input logic [1:0]  len,
  input logic [15:0] long_tgt,
  input logic        dp_wr,
  input logic        dp_hi,
  input logic [7:0]  dp_wdata,
  input logic [15:0] pc,
  input logic [15:0] dptr,
  input logic        sel_err
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (pc == 16'h0 && dptr == 16'h0 && !sel_err));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(pc));
  // R3
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src_sel == 4'b0001) |=> pc == $past(pc) + {14'b0, $past(len)});
  // R5
  long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src_sel == 4'b0100) |=> pc == $past(long_tgt));
  // R8
  dp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && !dp_hi) |=> (dptr[7:0] == $past(dp_wdata) && $stable(dptr[15:8])));
  // R8
  dp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && dp_hi) |=> (dptr[15:8] == $past(dp_wdata) && $stable(dptr[7:0])));
  // R10
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !$onehot(src_sel)) |=> (sel_err && $stable(pc)));
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || $onehot(src_sel)) |=> !sel_err);
endmodule

bind pc_next_unit pc_next_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .src_sel(src_sel), .len(len),
  .long_tgt(long_tgt), .dp_wr(dp_wr), .dp_hi(dp_hi), .dp_wdata(dp_wdata),
  .pc(pc), .dptr(dptr), .sel_err(sel_err)
);

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [3:0]  src_sel = 4'b0;
  logic [1:0]  len = 2'd1;
  logic [7:0]  rel_off = 8'h0;
  logic [15:0] long_tgt = 16'h0;
  logic [7:0]  acc = 8'h0;
  logic        tbl_pc_base = 1'b0;
  logic        dp_wr = 1'b0;
  logic        dp_hi = 1'b0;
  logic [7:0]  dp_wdata = 8'h0;
  logic [15:0] pc, dptr, code_addr;
  logic        sel_err;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pc_next_unit uut (
    .clk(clk), .rst_n(rst_n), .step(step), .src_sel(src_sel), .len(len),
    .rel_off(rel_off), .long_tgt(long_tgt), .acc(acc), .tbl_pc_base(tbl_pc_base),
    .dp_wr(dp_wr), .dp_hi(dp_hi), .dp_wdata(dp_wdata),
    .pc(pc), .dptr(dptr), .code_addr(code_addr), .sel_err(sel_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_step(input logic [3:0] s, input logic [1:0] l, input logic [7:0] off,
                         input logic [15:0] tgt, input logic [7:0] a);
    @(negedge clk);
    step = 1'b1; src_sel = s; len = l; rel_off = off; long_tgt = tgt; acc = a;
    @(posedge clk); #1;
    step = 1'b0;
  endtask

  task automatic dp_write(input logic hi, input logic [7:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_hi = hi; dp_wdata = d;
    @(posedge clk); #1;
    dp_wr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 pc", pc, 16'h0);
    chk("R1 dptr", dptr, 16'h0);
    chk("R1 err", {15'b0, sel_err}, 16'h0);
  endtask

  task automatic t_seq;
    do_step(4'b0001, 2'd1, 8'h0, 16'h0, 8'h0); chk("R3 len1", pc, 16'h0001);
    do_step(4'b0001, 2'd2, 8'h0, 16'h0, 8'h0); chk("R3 len2", pc, 16'h0003);
    do_step(4'b0001, 2'd3, 8'h0, 16'h0, 8'h0); chk("R3 len3", pc, 16'h0006);
  endtask

  task automatic t_hold;
    @(negedge clk);
    src_sel = 4'b0100; long_tgt = 16'hBEEF; len = 2'd3;
    repeat (3) @(posedge clk);
    #1 chk("R2 idle hold", pc, 16'h0006);
  endtask

  task automatic t_rel;
    do_step(4'b0010, 2'd2, 8'h10, 16'h0, 8'h0); chk("R4 forward", pc, 16'h0018);
    do_step(4'b0010, 2'd2, 8'h80, 16'h0, 8'h0); chk("R4 R9 back -128 wrap", pc, 16'hFF9A);
    do_step(4'b0010, 2'd1, 8'h7F, 16'h0, 8'h0); chk("R4 +127", pc, 16'h001A);
  endtask

  task automatic t_long;
    do_step(4'b0100, 2'd3, 8'h0, 16'h1234, 8'h0); chk("R5 long", pc, 16'h1234);
    do_step(4'b0100, 2'd3, 8'h0, 16'hFFFF, 8'h0); chk("R5 long top", pc, 16'hFFFF);
    do_step(4'b0001, 2'd3, 8'h0, 16'h0, 8'h0);    chk("R9 seq wrap", pc, 16'h0002);
  endtask

  task automatic t_dptr;
    dp_write(1'b0, 8'h04); chk("R8 low", dptr, 16'h0004);
    dp_write(1'b1, 8'h25); chk("R8 high", dptr, 16'h2504);
    dp_write(1'b0, 8'hAA); chk("R8 low keeps high", dptr, 16'h25AA);
  endtask

  task automatic t_table;
    @(negedge clk);
    acc = 8'hFF; tbl_pc_base = 1'b0;
    #1 chk("R7 dptr base", code_addr, 16'h26A9);
    tbl_pc_base = 1'b1; len = 2'd3;
    #1 chk("R7 pc base", code_addr, 16'h0104);
    tbl_pc_base = 1'b0;
    @(posedge clk); #1 chk("R2 table read no move", pc, 16'h0002);
  endtask

  task automatic t_index;
    do_step(4'b1000, 2'd1, 8'h0, 16'h0, 8'h80); chk("R6 indexed", pc, 16'h262A);
    @(negedge clk);
    dp_wr = 1'b1; dp_hi = 1'b1; dp_wdata = 8'h00;
    step = 1'b1; src_sel = 4'b1000; acc = 8'h01;
    @(posedge clk); #1;
    step = 1'b0; dp_wr = 1'b0;
    chk("R6 old dptr used", pc, 16'h25AB);
    chk("R8 write same cycle", dptr, 16'h00AA);
  endtask

  task automatic t_wrap_dptr;
    dp_write(1'b0, 8'hFF);
    dp_write(1'b1, 8'hFF);
    @(negedge clk);
    acc = 8'h02; tbl_pc_base = 1'b0;
    #1 chk("R9 table wrap", code_addr, 16'h0001);
  endtask

  task automatic t_illegal;
    do_step(4'b0011, 2'd1, 8'h0, 16'h0, 8'h0);
    chk("R10 two-hot hold", pc, 16'h25AB);
    chk("R10 err set", {15'b0, sel_err}, 16'h1);
    do_step(4'b0001, 2'd1, 8'h0, 16'h0, 8'h0);
    chk("R10 err clears", {15'b0, sel_err}, 16'h0);
    chk("R10 legal after", pc, 16'h25AC);
    do_step(4'b0000, 2'd1, 8'h0, 16'h0, 8'h0);
    chk("R10 zero hold", pc, 16'h25AC);
    chk("R10 zero err", {15'b0, sel_err}, 16'h1);
    @(posedge clk); #1 chk("R10 pulse only", {15'b0, sel_err}, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_seq();
    t_hold();
    t_rel();
    t_long();
    t_dptr();
    t_table();
    t_index();
    t_illegal();
    t_wrap_dptr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule